// File: doc/BRIEF.md
# Stochastic Decoder Frame Sequencer

This block paces the frames of a stochastic low-density parity-check decoder. Each frame begins with a load phase. In that phase the edge memories of the variable nodes are filled with channel bits, and the node-to-node wiring is held quiet by a suppress flag. The frame then moves to a decode phase, where the nodes trade stochastic bits freely. The load phase starts by asking the noise source for a fresh set of channel samples. It ends as soon as the edge memories report that they are full.

In the decode phase, the block watches one parity-satisfied flag from each check node. These flags cross a two-stage synchronizer before they are used. A frame succeeds when every flag is high in the same cycle. It fails when the phase has lasted a fixed number of clock cycles. Either outcome closes the frame with a one-cycle pulse and reopens the load phase. Saturating counters keep the number of good and failed frames. After a set number of frames, the block asks for the random-number seeds to be rotated.

Top module: `sdec_frame_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `load_o` and `noise_go_o` are 1. `frame_end_o`, `frame_err_o` and `seed_rot_o` are 0, and both frame counters read 0.
- R2: `noise_go_o` is high only in the first cycle of each load phase. `load_o` stays 1 for as long as `mem_full_i` is sampled 0.
- R3: After a clock edge in the load phase that samples `mem_full_i` = 1, `load_o` is 0. It stays 0 until the frame ends.
- R4: `chk_ok_i` reaches the decision through two flops, which are cleared during the load phase. If all flags are already 1 before decoding starts, the decode phase lasts exactly 3 cycles. If they first become all 1 before the edge that ends decode cycle j, the decode phase lasts j+2 cycles.
- R5: A successful frame gives one cycle with `frame_end_o` = 1 and `frame_err_o` = 0. It adds one to `good_cnt_o` and sets `load_o` = 1.
- R6: A decode phase in which not all flags are seen high lasts exactly TIMEOUT cycles. It then gives one cycle with `frame_end_o` = 1 and `frame_err_o` = 1, and adds one to `bad_cnt_o`.
- R7: If success and timeout fall on the same edge, the frame counts as a success.
- R8: A flag vector that is not all ones never ends a frame early.
- R9: `seed_rot_o` pulses together with `noise_go_o` at the start of the load phase that follows every ROT_FRAMES-th frame end after reset.
- R10: Both frame counters are CNT_W bits wide and hold at their maximum value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chk_ok_i | input | N_CHK | Parity-satisfied flag per check node (asynchronous) |
| mem_full_i | input | 1 | Edge memories hold a full preload |
| load_o | output | 1 | Load phase; suppresses inter-node signals |
| noise_go_o | output | 1 | One-cycle request for a new noise frame |
| seed_rot_o | output | 1 | One-cycle seed rotation and LFSR reload request |
| frame_end_o | output | 1 | One-cycle pulse at the end of every frame |
| frame_err_o | output | 1 | One-cycle pulse when a frame times out |
| good_cnt_o | output | CNT_W | Saturating count of successful frames |
| bad_cnt_o | output | CNT_W | Saturating count of timed-out frames |

## Verification
Two exits can fall on the same edge: the synchronized all-satisfied condition and the expiry of the decode timer. The bench raises every flag before the edge that ends decode cycle TIMEOUT-2. The success then emerges from the synchronizer on exactly the cycle the timer expires. That frame must be counted as good, with no error pulse and a decode length of TIMEOUT. The same flags raised one cycle later must give a timeout instead.

// File: rtl/sdec_pkg.sv
package sdec_pkg;
  typedef enum logic {
    PH_LOAD = 1'b0,
    PH_DEC  = 1'b1
  } phase_t;
endpackage

// File: rtl/sdec_sync.sv
module sdec_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

  AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q == '0)); // R4
endmodule

// File: rtl/sdec_modcnt.sv
module sdec_modcnt #(
  parameter int LIMIT = 300
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic last
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign last = (cnt == TOP);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (en) begin
      cnt <= last ? '0 : cnt + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= TOP); // R6
endmodule

// File: rtl/sdec_satcnt.sv
module sdec_satcnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (inc && (q != MAXV)) begin
      q <= q + 1'b1;
    end
  end

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (q == MAXV) |=> (q == MAXV)); // R10
  AST_SAT_STEP: assert property (@(posedge clk) disable iff (rst)
    (q != $past(q)) |-> (q == $past(q) + 1'b1)); // R10
endmodule

// File: rtl/sdec_frame_ctrl.sv
module sdec_frame_ctrl
  import sdec_pkg::*;
#(
  parameter int N_CHK      = 8,
  parameter int TIMEOUT    = 300,
  parameter int ROT_FRAMES = 256,
  parameter int CNT_W      = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_CHK-1:0] chk_ok_i,
  input  logic             mem_full_i,
  output logic             load_o,
  output logic             noise_go_o,
  output logic             seed_rot_o,
  output logic             frame_end_o,
  output logic             frame_err_o,
  output logic [CNT_W-1:0] good_cnt_o,
  output logic [CNT_W-1:0] bad_cnt_o
);
  phase_t           phase;
  logic [N_CHK-1:0] chk_sync;
  logic             in_dec;
  logic             all_ok;
  logic             tmo_last;
  logic             rot_last;
  logic             win;
  logic             lose;
  logic             fin;

  assign in_dec = (phase == PH_DEC);
  assign all_ok = &chk_sync;
  assign win    = in_dec && all_ok;
  assign lose   = in_dec && !all_ok && tmo_last;
  assign fin    = win || lose;

  sdec_sync #(.W(N_CHK)) u_sync (
    .clk (clk),
    .rst (rst),
    .clr (!in_dec),
    .d   (chk_ok_i),
    .q   (chk_sync)
  );

  sdec_modcnt #(.LIMIT(TIMEOUT)) u_tmo (
    .clk  (clk),
    .rst  (rst),
    .clr  (!in_dec),
    .en   (in_dec),
    .last (tmo_last)
  );

  sdec_modcnt #(.LIMIT(ROT_FRAMES)) u_rot (
    .clk  (clk),
    .rst  (rst),
    .clr  (1'b0),
    .en   (fin),
    .last (rot_last)
  );

  sdec_satcnt #(.W(CNT_W)) u_good (
    .clk (clk),
    .rst (rst),
    .inc (win),
    .q   (good_cnt_o)
  );

  sdec_satcnt #(.W(CNT_W)) u_bad (
    .clk (clk),
    .rst (rst),
    .inc (lose),
    .q   (bad_cnt_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_LOAD;
      load_o      <= 1'b1;
      noise_go_o  <= 1'b1;
      seed_rot_o  <= 1'b0;
      frame_end_o <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      frame_end_o <= fin;
      frame_err_o <= lose;
      noise_go_o  <= fin;
      seed_rot_o  <= fin && rot_last;
      case (phase)
        PH_LOAD: begin
          if (mem_full_i) begin
            phase  <= PH_DEC;
            load_o <= 1'b0;
          end
        end
        default: begin
          if (fin) begin
            phase  <= PH_LOAD;
            load_o <= 1'b1;
          end
        end
      endcase
    end
  end

  AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (load_o && !mem_full_i) |=> load_o); // R2
  AST_NOISE_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(load_o) |-> noise_go_o); // R2
  AST_ROT_WITH_NOISE: assert property (@(posedge clk) disable iff (rst)
    seed_rot_o |-> noise_go_o); // R9
  AST_ERR_IS_END: assert property (@(posedge clk) disable iff (rst)
    frame_err_o |-> (frame_end_o && load_o)); // R6
  AST_GOOD_ON_WIN: assert property (@(posedge clk) disable iff (rst)
    (good_cnt_o != $past(good_cnt_o)) |-> (frame_end_o && !frame_err_o)); // R5
endmodule

// File: tb/tb_sdec_frame_ctrl.sv
`timescale 1ns/1ps
module tb_sdec_frame_ctrl;
  localparam int NC  = 4;
  localparam int TMO = 12;
  localparam int ROT = 3;
  localparam int CW  = 3;
  localparam int NV  = 14;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  // {mem_full delay, flag pattern, decode cycle to raise flags (0 = during load)}
  localparam logic [12:0] VEC [NV] = '{
    {4'd1, 4'hF, 5'd0},  {4'd2, 4'hF, 5'd1},  {4'd0, 4'hF, 5'd5},
    {4'd3, 4'h7, 5'd1},  {4'd1, 4'hF, 5'd10}, {4'd1, 4'hF, 5'd11},
    {4'd0, 4'hE, 5'd2},  {4'd4, 4'hF, 5'd3},  {4'd1, 4'hF, 5'd0},
    {4'd2, 4'hF, 5'd2},  {4'd1, 4'hF, 5'd4},  {4'd1, 4'hF, 5'd6},
    {4'd1, 4'h0, 5'd1},  {4'd0, 4'hF, 5'd1}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NC-1:0] chk_ok = '0;
  logic          mem_full = 1'b0;
  logic          load, noise_go, seed_rot, frame_end, frame_err;
  logic [CW-1:0] good_cnt, bad_cnt;

  int n_chk = 0;
  int n_fail = 0;
  int exp_good = 0;
  int exp_bad = 0;
  int n_ends = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sdec_frame_ctrl #(.N_CHK(NC), .TIMEOUT(TMO), .ROT_FRAMES(ROT), .CNT_W(CW)) dut (
    .clk         (clk),
    .rst         (rst),
    .chk_ok_i    (chk_ok),
    .mem_full_i  (mem_full),
    .load_o      (load),
    .noise_go_o  (noise_go),
    .seed_rot_o  (seed_rot),
    .frame_end_o (frame_end),
    .frame_err_o (frame_err),
    .good_cnt_o  (good_cnt),
    .bad_cnt_o   (bad_cnt)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [3:0] dly, input logic [3:0] pat, input int at);
    int  run;
    bit  ok;
    int  exp_run;
    ok      = (pat == 4'hF) && (at + 2 <= TMO);
    exp_run = !ok ? TMO : (at == 0 ? 3 : at + 2);
    chk_ok  = (at == 0) ? pat : '0;
    for (int i = 0; i < int'(dly); i++) begin
      @(negedge clk);
      if (i == 0) begin
        check("R2 noise trigger one cycle", int'(noise_go), 0);
        check("R2 load held without mem_full", int'(load), 1);
      end
    end
    mem_full = 1'b1;
    run = 0;
    for (int g = 0; g < 4 * TMO; g++) begin
      @(negedge clk);
      if (!load) begin
        mem_full = 1'b0;
        run++;
        if (run == at) chk_ok = pat;
      end else if (run > 0) begin
        break;
      end
    end
    chk_ok = '0;
    if (ok) begin
      exp_good = (exp_good < int'(CMAX)) ? exp_good + 1 : exp_good;
    end else begin
      exp_bad = (exp_bad < int'(CMAX)) ? exp_bad + 1 : exp_bad;
    end
    n_ends++;
    if (ok) check(at == TMO - 2 ? "R7 decode length" : "R4 decode length", run, exp_run);
    else    check(pat == 4'hF ? "R6 decode length" : "R8 decode length", run, exp_run);
    check("R5 frame_end pulse", int'(frame_end), 1);
    check(ok ? "R5 no error on success" : "R6 error pulse", int'(frame_err), ok ? 0 : 1);
    check("R5 good count", int'(good_cnt), exp_good);
    check("R6 bad count", int'(bad_cnt), exp_bad);
    check("R2 noise trigger at load entry", int'(noise_go), 1);
    check("R9 seed rotation", int'(seed_rot), (n_ends % ROT == 0) ? 1 : 0);
  endtask

  initial begin
    #(5.0 * 40000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check("R1 load after reset", int'(load), 1);
    check("R1 noise trigger after reset", int'(noise_go), 1);
    check("R1 no frame_end", int'(frame_end), 0);
    check("R1 no error", int'(frame_err), 0);
    check("R1 no rotation", int'(seed_rot), 0);
    check("R1 good count zero", int'(good_cnt), 0);
    check("R1 bad count zero", int'(bad_cnt), 0);

    for (int v = 0; v < NV; v++) begin
      run_frame(VEC[v][12:9], VEC[v][8:5], int'(VEC[v][4:0]));
    end
    check("R10 good count saturated", int'(good_cnt), int'(CMAX));

    // R3: decoding holds load low while mem_full stays low and flags stay clear
    mem_full = 1'b1;
    @(negedge clk);
    mem_full = 1'b0;
    repeat (3) @(negedge clk);
    check("R3 load low during decode", int'(load), 0);

    // R1: reset in the middle of decoding
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1 load after mid-frame reset", int'(load), 1);
    check("R1 noise trigger after mid-frame reset", int'(noise_go), 1);
    check("R1 good count cleared", int'(good_cnt), 0);
    check("R1 bad count cleared", int'(bad_cnt), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule